// File: doc/BRIEF.md
# SDRAM Power-On Initialisation Sequencer

This block brings an SDRAM device from power-up to normal use. After reset it waits for one configuration load, which latches three values: the idle gap between initialisation commands, a refresh prescaler, and a refresh period. It then drives the start-up command series towards a downstream SDRAM command/PHY stage over a valid/ready command interface. The series is one precharge of all banks, then a fixed number of auto refreshes (eight by default), then a load of the device mode register.

Once the last start-up command has been accepted and its gap has elapsed, the block enters normal mode and raises `initDone`. From then on a prescaled refresh timer raises REFRESH requests on the same command interface at a fixed interval. A controller placed after this block takes over all other traffic.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rstN` is low, `cmdValid` and `initDone` are 0.
- R2: No command is presented before the first `cfgLoad` pulse after reset. The gap, prescaler and period values are captured on that pulse.
- R3: The first command presented is precharge-all banks, code 2'd1.
- R4: Exactly `INIT_REFRESHES` (default 8) auto-refresh commands, code 2'd2, follow the precharge-all.
- R5: A mode-register-set command, code 2'd3, follows the refreshes and is the last start-up command.
- R6: After each accepted start-up command, `cmdValid` stays low for exactly G cycles before the next start-up command, where G is the captured gap value. When G is 0 the commands are back to back.
- R7: A presented command keeps `cmdValid` high and `cmdCode` unchanged until a cycle in which `cmdReady` is high.
- R8: `initDone` rises G cycles after the mode-set command is accepted. It stays high until the next reset.
- R9: In normal mode a refresh request (code 2'd2) is raised every (P+1)*(N+1) cycles, where P is the captured prescaler value and N is the captured period value. The first request comes that many cycles after `initDone` rises.
- R10: Any `cfgLoad` pulse after the first one is ignored. The gap and the refresh interval keep their captured values.
- R11: A refresh request that is not accepted stays presented as a single request. Timer expiries that occur while it waits merge into it. It drops the cycle after it is accepted, and the timer phase is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Pulse that captures the configuration (first one only) |
| cfgGap | input | GAP_W | Idle cycles between start-up commands |
| cfgPrescale | input | PRE_W | Refresh prescaler value P (divide by P+1) |
| cfgPeriod | input | PER_W | Refresh period N in prescaled ticks (N+1 ticks) |
| cmdValid | output | 1 | Command presented |
| cmdCode | output | 2 | Command code: 1 precharge-all, 2 refresh, 3 mode set |
| cmdReady | input | 1 | Downstream stage accepts the command this cycle |
| initDone | output | 1 | Start-up finished, normal mode active |

## Verification
The hardest situation to reach is a stalled refresh request whose wait spans a further timer expiry. The merge and the undisturbed timer phase only show up when `cmdReady` is held low for longer than one whole refresh interval. The bench reaches it by computing the interval for each configuration and dropping `cmdReady` exactly when the fourth request appears. It keeps `cmdReady` low across the next expiry, then checks that only one request drops after acceptance and that the following request lands on the original phase. It sweeps every gap, prescaler, period and stall combination, so back-to-back start-up commands and stalled handshakes also occur together.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP           = 2'd0,
    CMD_PRECHARGE_ALL = 2'd1,
    CMD_REFRESH       = 2'd2,
    CMD_MODE_SET      = 2'd3
  } sdramCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;     // capture configuration
    logic gapStart;    // load gap counter with G-1
    logic gapStep;     // decrement gap counter
    logic timerRun;    // refresh timer counting
    logic refreshAck;  // pending refresh accepted
  } initCtl_t;

endpackage

// File: rtl/sdram_init_datapath.sv
module sdram_init_datapath
  import sdram_init_pkg::*;
#(
  parameter int GAP_W = 4,
  parameter int PRE_W = 4,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  initCtl_t         ctl,
  input  logic [GAP_W-1:0] cfgGap,
  input  logic [PRE_W-1:0] cfgPrescale,
  input  logic [PER_W-1:0] cfgPeriod,
  output logic             gapIsZero,
  output logic             gapCfgZero,
  output logic             refreshPending
);

  logic [GAP_W-1:0] gapReg, gapCnt;
  logic [PRE_W-1:0] preReg, preCnt;
  logic [PER_W-1:0] perReg, perCnt;
  logic             preWrap, perWrap, timerFire;

  assign gapIsZero  = (gapCnt == '0);
  assign gapCfgZero = (gapReg == '0);
  assign preWrap    = (preCnt == preReg);
  assign perWrap    = (perCnt == perReg);
  assign timerFire  = ctl.timerRun && preWrap && perWrap;

  // configuration capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapReg <= '0;
      preReg <= '0;
      perReg <= '0;
    end else if (ctl.loadCfg) begin
      gapReg <= cfgGap;
      preReg <= cfgPrescale;
      perReg <= cfgPeriod;
    end
  end

  // inter-command gap counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (ctl.gapStart) begin
      gapCnt <= gapReg - GAP_W'(1);
    end else if (ctl.gapStep) begin
      gapCnt <= gapCnt - GAP_W'(1);
    end
  end

  // prescaled refresh timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (ctl.timerRun) begin
      if (preWrap) begin
        preCnt <= '0;
        perCnt <= perWrap ? '0 : perCnt + PER_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  // single pending refresh request; a new expiry wins over an ack
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refreshPending <= 1'b0;
    end else if (timerFire) begin
      refreshPending <= 1'b1;
    end else if (ctl.refreshAck) begin
      refreshPending <= 1'b0;
    end
  end

  assert_prescale_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preReg);

  assert_pending_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    refreshPending && !ctl.refreshAck |=> refreshPending);

endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int INIT_REFRESHES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgLoad,
  input  logic       cmdReady,
  input  logic       gapIsZero,
  input  logic       gapCfgZero,
  input  logic       refreshPending,
  output initCtl_t   ctl,
  output logic       cmdValid,
  output logic [1:0] cmdCode,
  output logic       initDone
);

  localparam int LAST_STEP = INIT_REFRESHES + 1;
  localparam int STEP_W    = $clog2(LAST_STEP + 1);

  typedef enum logic [1:0] {ST_WAIT_CFG, ST_ISSUE, ST_GAP, ST_NORMAL} state_e;

  state_e      state, stateNext;
  logic [STEP_W-1:0] step, stepNext;
  sdramCmd_e   stepCmd;
  logic        isLast;

  assign isLast = (step == STEP_W'(LAST_STEP));

  always_comb begin
    if (step == '0)  stepCmd = CMD_PRECHARGE_ALL;
    else if (isLast) stepCmd = CMD_MODE_SET;
    else             stepCmd = CMD_REFRESH;
  end

  assign cmdValid = (state == ST_ISSUE) || ((state == ST_NORMAL) && refreshPending);
  assign cmdCode  = (state == ST_NORMAL) ? CMD_REFRESH : stepCmd;
  assign initDone = (state == ST_NORMAL);

  always_comb begin
    stateNext = state;
    stepNext  = step;
    ctl       = '0;
    unique case (state)
      ST_WAIT_CFG: begin
        if (cfgLoad) begin
          ctl.loadCfg = 1'b1;
          stepNext    = '0;
          stateNext   = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (cmdReady) begin
          if (!gapCfgZero) begin
            ctl.gapStart = 1'b1;
            stateNext    = ST_GAP;
          end else if (isLast) begin
            stateNext = ST_NORMAL;
          end else begin
            stepNext = step + STEP_W'(1);
          end
        end
      end
      ST_GAP: begin
        if (!gapIsZero) begin
          ctl.gapStep = 1'b1;
        end else if (isLast) begin
          stateNext = ST_NORMAL;
        end else begin
          stepNext  = step + STEP_W'(1);
          stateNext = ST_ISSUE;
        end
      end
      ST_NORMAL: begin
        ctl.timerRun   = 1'b1;
        ctl.refreshAck = refreshPending && cmdReady;
      end
      default: stateNext = ST_WAIT_CFG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_WAIT_CFG;
      step  <= '0;
    end else begin
      state <= stateNext;
      step  <= stepNext;
    end
  end

  assert_cmd_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdCode));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  assert_mode_before_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> $past(cmdCode) == CMD_MODE_SET);

  assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    step <= STEP_W'(LAST_STEP));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int GAP_W          = 4,
  parameter int PRE_W          = 4,
  parameter int PER_W          = 8,
  parameter int INIT_REFRESHES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [GAP_W-1:0] cfgGap,
  input  logic [PRE_W-1:0] cfgPrescale,
  input  logic [PER_W-1:0] cfgPeriod,
  output logic             cmdValid,
  output logic [1:0]       cmdCode,
  input  logic             cmdReady,
  output logic             initDone
);

  initCtl_t ctl;
  logic     gapIsZero, gapCfgZero, refreshPending;

  sdram_init_ctrl #(.INIT_REFRESHES(INIT_REFRESHES)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cmdReady(cmdReady),
    .gapIsZero(gapIsZero), .gapCfgZero(gapCfgZero),
    .refreshPending(refreshPending), .ctl(ctl),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .initDone(initDone)
  );

  sdram_init_datapath #(.GAP_W(GAP_W), .PRE_W(PRE_W), .PER_W(PER_W)) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cfgGap(cfgGap), .cfgPrescale(cfgPrescale), .cfgPeriod(cfgPeriod),
    .gapIsZero(gapIsZero), .gapCfgZero(gapCfgZero),
    .refreshPending(refreshPending)
  );

endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;
  localparam int GAP_W = 4;
  localparam int PRE_W = 4;
  localparam int PER_W = 8;
  localparam int NREF  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic cmdReady = 1'b0;
  logic [GAP_W-1:0] cfgGap = '0;
  logic [PRE_W-1:0] cfgPrescale = '0;
  logic [PER_W-1:0] cfgPeriod = '0;
  logic cmdValid;
  logic [1:0] cmdCode;
  logic initDone;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdram_init_seq #(.GAP_W(GAP_W), .PRE_W(PRE_W), .PER_W(PER_W), .INIT_REFRESHES(NREF))
    i_sdram_init_seq (
      .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgGap(cfgGap),
      .cfgPrescale(cfgPrescale), .cfgPeriod(cfgPeriod),
      .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdReady(cmdReady),
      .initDone(initDone));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCode(input int idx);
    if (idx == 0) return 1;
    if (idx <= NREF) return 2;
    return 3;
  endfunction

  task automatic runConfig(input int g, input int p, input int n, input bit stall);
    int k = (p + 1) * (n + 1);
    int expIdx = 0;
    int lowRun = -1;
    int cyc = 0;
    bit prevStall = 0;
    int prevCode = 0;
    bit doneSeen = 0;
    bit expV;
    rstN = 1'b0; cfgLoad = 1'b0; cmdReady = 1'b1;
    cfgGap = GAP_W'(g); cfgPrescale = PRE_W'(p); cfgPeriod = PER_W'(n);
    repeat (3) @(negedge clk);
    chk("R1 cmdValid in reset", int'(cmdValid), 0);
    chk("R1 initDone in reset", int'(initDone), 0);
    rstN = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R2 idle before load", int'(cmdValid), 0);
    end
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    while (!doneSeen && cyc < 1000) begin
      cyc++;
      if (cyc == 2) begin // R10: change inputs and pulse load again
        cfgGap = GAP_W'(g + 5); cfgPrescale = PRE_W'(p + 3); cfgPeriod = PER_W'(n + 4);
      end
      cfgLoad  = (cyc == 2 || cyc == 3);
      cmdReady = stall ? ((cyc % 3) != 1) : 1'b1;
      if (prevStall) begin
        chk("R7 valid held", int'(cmdValid), 1);
        chk("R7 code held", int'(cmdCode), prevCode);
      end
      if (initDone) begin
        chk("R8 gap before done", lowRun, g);
        chk("R4 start-up command count", expIdx, NREF + 2);
        doneSeen = 1;
      end else if (cmdValid) begin
        if (lowRun >= 0) chk("R6 R10 idle gap", lowRun, g);
        lowRun = -1;
        if (cmdReady) begin
          if (expIdx == 0) chk("R3 first command", int'(cmdCode), expCode(expIdx));
          else if (expIdx <= NREF) chk("R4 refresh command", int'(cmdCode), expCode(expIdx));
          else chk("R5 mode set command", int'(cmdCode), expCode(expIdx));
          expIdx++;
          lowRun = 0;
        end
      end else if (lowRun >= 0) begin
        lowRun++;
      end
      prevStall = cmdValid && !cmdReady;
      prevCode  = int'(cmdCode);
      if (!doneSeen) @(negedge clk);
    end
    chk("R8 done reached", int'(doneSeen), 1);
    cmdReady = 1'b1;
    for (int t = 1; t <= 6 * k; t++) begin
      @(negedge clk);
      cfgLoad  = (t == k + 1); // R10 ignored in normal mode
      cmdReady = !(t >= 4 * k && t <= 5 * k);
      expV = ((t % k == 0) && t < 4 * k) || (t >= 4 * k && t <= 5 * k + 1) || (t == 6 * k);
      if (t < 4 * k || t == 6 * k) chk("R9 R10 refresh interval", int'(cmdValid), int'(expV));
      else chk("R11 stalled refresh", int'(cmdValid), int'(expV));
      if (cmdValid) chk("R9 refresh code", int'(cmdCode), 2);
      chk("R8 done stays high", int'(initDone), 1);
    end
    cfgLoad = 1'b0;
  endtask

  initial begin
    for (int g = 0; g < 4; g++)
      for (int p = 0; p < 3; p++)
        for (int n = 1; n < 3; n++)
          for (int s = 0; s < 2; s++)
            if ((p + 1) * (n + 1) >= 3) runConfig(g, p, n, s[0]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule